// File: doc/BRIEF.md
# Program Counter and Instruction Register

This block keeps the two fetch-side registers of a microcoded processor: a 32-bit program counter and a 32-bit instruction register. Three single-bit controls from the current microword drive it. One captures the word that memory returns into the instruction register. One steps the program counter by one. One moves the program counter by a signed relative offset.

The instruction register is split into a 17-bit opcode and three 5-bit register selectors. These fields go to the microsequencer and to the register file. The relative offset is formed inside the block from two of those fields, the destination selector and the second source selector. The program counter value goes out to the memory address multiplexer.

Top module: `fetch_regs`

## Requirements
- R1: With `rst_n` low at a rising clock edge, the program counter and the instruction register are both zero after that edge, so every output of the block reads zero.
- R2: With `ir_load` high at a rising edge, the instruction register takes `mem_rdata`. With `ir_load` low, it keeps its value and `mem_rdata` has no effect on any output.
- R3: The instruction register fields are fixed. `opcode` is bits 31..15, `dst_sel` is bits 14..10, `srca_sel` is bits 9..5 and `srcb_sel` is bits 4..0. Each field is valid in the cycle after the load edge.
- R4: With `pc_step` high and `pc_jump` low at an edge, the program counter becomes its old value plus one. The count wraps modulo 2^32, so 32'hFFFFFFFF steps to 0.
- R5: With `pc_jump` high at an edge, the program counter becomes its old value plus an offset. The offset is the 10-bit value {`dst_sel`, `srcb_sel`}, with `dst_sel` as the upper five bits, sign-extended to 32 bits. The result wraps modulo 2^32.
- R6: When bit 4 of `dst_sel` is 1, the offset is negative and the program counter moves backward. For example, {5'b11111, 5'b11110} moves it back by 2.
- R7: When `pc_jump` and `pc_step` are both high, only the offset move takes place.
- R8: When `pc_jump` and `pc_step` are both low, the program counter keeps its value.
- R9: When `ir_load` and `pc_jump` are high in the same cycle, the offset comes from the instruction register content before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| ir_load | input | 1 | Capture `mem_rdata` into the instruction register |
| pc_step | input | 1 | Advance the program counter by one |
| pc_jump | input | 1 | Add the sign-extended field offset to the program counter |
| mem_rdata | input | 32 | Word read from memory |
| pc_out | output | 32 | Current program counter |
| opcode | output | 17 | Opcode field of the instruction register |
| dst_sel | output | 5 | Destination register field |
| srca_sel | output | 5 | First source register field |
| srcb_sel | output | 5 | Second source register field |

## Verification
Every result of this block is due exactly one clock after the edge that samples its control. A program counter update, a field change after a load, and the cleared state after reset all appear one edge later, because each passes through a single register. The bench changes its inputs on the falling edge and reads the outputs on the next falling edge, half a period after the register has updated. In the same-cycle load-and-jump case, the bench works out the expected counter from the fields it had read before that edge.

// File: rtl/fetch_pkg.sv
// Package: fetch_pkg
// Shared widths and the packed layout of an instruction word.
// Assumes the opcode and the three selectors fill the whole word exactly.
package fetch_pkg;
    localparam int WORD_W = 32;
    localparam int OPC_W  = 17;
    localparam int SEL_W  = 5;
    localparam int OFS_W  = 2 * SEL_W;

    typedef struct packed {
        logic [OPC_W-1:0] opc;
        logic [SEL_W-1:0] dst;
        logic [SEL_W-1:0] srca;
        logic [SEL_W-1:0] srcb;
    } instr_t;
endpackage

// File: rtl/instr_reg.sv
// Module: instr_reg
// Instruction holding register. Loads din when load is high, otherwise holds.
// Assumes a synchronous active-low reset that clears it to zero.
module instr_reg #(
    parameter int W = fetch_pkg::WORD_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] din,
    output logic [W-1:0] q
);
    // Capture the memory word or keep the current instruction.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else if (load)
            q <= din;
    end
endmodule

// File: rtl/offset_ext.sv
// Module: offset_ext
// Joins two selector fields (hi above lo) and sign-extends the result to OUT_W.
// Assumes OUT_W is not smaller than the joined width.
module offset_ext #(
    parameter int SEL_W = fetch_pkg::SEL_W,
    parameter int OUT_W = fetch_pkg::WORD_W
) (
    input  logic [SEL_W-1:0] hi,
    input  logic [SEL_W-1:0] lo,
    output logic [OUT_W-1:0] ofs
);
    localparam int JW  = 2 * SEL_W;
    localparam int PAD = OUT_W - JW;

    logic [JW-1:0] joined;

    // Replicate the top bit of the joined value above it.
    always_comb begin
        joined = {hi, lo};
        ofs    = {{PAD{joined[JW-1]}}, joined};
    end
endmodule

// File: rtl/prog_counter.sv
// Module: prog_counter
// Program counter. A jump adds ofs, a step adds one, and a jump wins over a step.
// With neither control high the count holds. Arithmetic wraps at W bits.
module prog_counter #(
    parameter int W = fetch_pkg::WORD_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step,
    input  logic         jump,
    input  logic [W-1:0] ofs,
    output logic [W-1:0] pc
);
    logic [W-1:0] pc_nxt;

    // Choose the next count by priority: jump, then step, then hold.
    always_comb begin
        if (jump)
            pc_nxt = pc + ofs;
        else if (step)
            pc_nxt = pc + W'(1);
        else
            pc_nxt = pc;
    end

    // Register the next count, or clear it under reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pc <= '0;
        else
            pc <= pc_nxt;
    end
endmodule

// File: rtl/fetch_regs.sv
// Module: fetch_regs (top)
// Holds the program counter and the instruction register and splits the
// instruction into opcode and selector fields. The relative offset comes from
// the registered fields, so a same-cycle load does not affect that jump.
module fetch_regs (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ir_load,
    input  logic        pc_step,
    input  logic        pc_jump,
    input  logic [31:0] mem_rdata,
    output logic [31:0] pc_out,
    output logic [16:0] opcode,
    output logic [4:0]  dst_sel,
    output logic [4:0]  srca_sel,
    output logic [4:0]  srcb_sel
);
    import fetch_pkg::*;

    logic [WORD_W-1:0] ir_q;
    logic [WORD_W-1:0] ofs;
    instr_t            fld;

    instr_reg #(.W(WORD_W)) ir_i (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (ir_load),
        .din   (mem_rdata),
        .q     (ir_q)
    );

    // View the stored word through the packed field layout.
    always_comb begin
        fld      = instr_t'(ir_q);
        opcode   = fld.opc;
        dst_sel  = fld.dst;
        srca_sel = fld.srca;
        srcb_sel = fld.srcb;
    end

    offset_ext #(.SEL_W(SEL_W), .OUT_W(WORD_W)) ext_i (
        .hi  (fld.dst),
        .lo  (fld.srcb),
        .ofs (ofs)
    );

    prog_counter #(.W(WORD_W)) pc_i (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (pc_step),
        .jump  (pc_jump),
        .ofs   (ofs),
        .pc    (pc_out)
    );
endmodule

// File: rtl/fetch_regs_chk.sv
// Module: fetch_regs_chk
// Checker for fetch_regs, attached by bind. Watches only the top-level ports.
module fetch_regs_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        ir_load,
    input logic        pc_step,
    input logic        pc_jump,
    input logic [31:0] mem_rdata,
    input logic [31:0] pc_out,
    input logic [16:0] opcode,
    input logic [4:0]  dst_sel,
    input logic [4:0]  srca_sel,
    input logic [4:0]  srcb_sel
);
    logic [31:0] word_view;
    logic [31:0] sext_ofs;

    // Rebuild the word and the offset from the output fields.
    always_comb begin
        word_view = {opcode, dst_sel, srca_sel, srcb_sel};
        sext_ofs  = 32'($signed({dst_sel, srcb_sel}));
    end

    // R2
    ir_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ir_load |=> word_view == $past(mem_rdata));

    // R2
    ir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ir_load |=> $stable(word_view));

    // R4
    pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_step && !pc_jump) |=> pc_out == $past(pc_out) + 32'd1);

    // R5
    pc_jump_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pc_jump |=> pc_out == $past(pc_out) + $past(sext_ofs));

    // R8
    pc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pc_step && !pc_jump) |=> $stable(pc_out));
endmodule

bind fetch_regs fetch_regs_chk chk_i (.*);

// File: tb/fetch_regs_tb_top.sv
// Directed bench for fetch_regs. Inputs change on the falling edge and outputs
// are read on the next falling edge, one register stage after the rising edge.
module fetch_regs_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ir_load = 1'b0;
    logic        pc_step = 1'b0;
    logic        pc_jump = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic [31:0] pc_out;
    logic [16:0] opcode;
    logic [4:0]  dst_sel, srca_sel, srcb_sel;

    int n_chk = 0;
    int n_bad = 0;
    logic [31:0] exp_pc;

    always #4 clk = ~clk;

    fetch_regs dut_i (.*);

    // Count one check and report a failure.
    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One clock: the inputs set now are sampled at the rising edge, and results are read at the next falling edge.
    task automatic cyc(input logic il, input logic ps, input logic pj, input logic [31:0] d);
        ir_load = il; pc_step = ps; pc_jump = pj; mem_rdata = d;
        @(negedge clk);
        ir_load = 0; pc_step = 0; pc_jump = 0;
    endtask

    function automatic logic [31:0] ofs_of(input logic [4:0] hi, input logic [4:0] lo);
        logic [9:0] j = {hi, lo};
        return {{22{j[9]}}, j};
    endfunction

    function automatic logic [31:0] word_of(input logic [16:0] op, input logic [4:0] d,
                                            input logic [4:0] a, input logic [4:0] b);
        return {op, d, a, b};
    endfunction

    task automatic t_reset();
        rst_n = 0;
        cyc(1, 1, 0, 32'hFFFF_FFFF);
        chk("R1 pc", pc_out, 32'd0);
        chk("R1 ir", {opcode, dst_sel, srca_sel, srcb_sel}, 32'd0);
        rst_n = 1;
        exp_pc = 0;
    endtask

    task automatic t_fields();
        cyc(1, 0, 0, 32'hABCD_1234);
        chk("R3 opcode", 32'(opcode), 32'(17'h1579A));
        chk("R3 dst_sel", 32'(dst_sel), 32'd4);
        chk("R3 srca_sel", 32'(srca_sel), 32'h11);
        chk("R3 srcb_sel", 32'(srcb_sel), 32'h14);
        cyc(1, 0, 0, 32'h5A5A_C3C3);
        chk("R2 load", {opcode, dst_sel, srca_sel, srcb_sel}, 32'h5A5A_C3C3);
    endtask

    task automatic t_ir_hold();
        cyc(0, 0, 0, 32'h1111_2222);
        chk("R2 hold", {opcode, dst_sel, srca_sel, srcb_sel}, 32'h5A5A_C3C3);
    endtask

    task automatic t_step_hold();
        for (int i = 0; i < 3; i++) cyc(0, 1, 0, 0);
        exp_pc = exp_pc + 3;
        chk("R4 step", pc_out, exp_pc);
        cyc(0, 0, 0, 32'hDEAD_BEEF);
        cyc(0, 0, 0, 0);
        chk("R8 hold", pc_out, exp_pc);
    endtask

    task automatic t_jump_pos();
        cyc(1, 0, 0, word_of(17'h1, 5'd0, 5'd9, 5'd5));
        cyc(0, 0, 1, 0);
        exp_pc = exp_pc + 5;
        chk("R5 jump +5", pc_out, exp_pc);
        cyc(1, 0, 0, word_of(17'h2, 5'b01111, 5'd0, 5'b11111));
        cyc(0, 0, 1, 0);
        exp_pc = exp_pc + 32'd511;
        chk("R5 jump +511", pc_out, exp_pc);
    endtask

    task automatic t_jump_neg();
        cyc(1, 0, 0, word_of(17'h3, 5'b11111, 5'd1, 5'b11110));
        cyc(0, 0, 1, 0);
        exp_pc = exp_pc - 2;
        chk("R6 jump -2", pc_out, exp_pc);
        cyc(1, 0, 0, word_of(17'h4, 5'b10000, 5'd0, 5'b00000));
        cyc(0, 0, 1, 0);
        exp_pc = exp_pc - 512;
        chk("R6 jump -512", pc_out, exp_pc);
    endtask

    task automatic t_both();
        cyc(1, 0, 0, word_of(17'h5, 5'd0, 5'd0, 5'd7));
        cyc(0, 1, 1, 0);
        exp_pc = exp_pc + 7;
        chk("R7 jump over step", pc_out, exp_pc);
    endtask

    task automatic t_wrap();
        rst_n = 0; cyc(0, 0, 0, 0); rst_n = 1;
        cyc(1, 0, 0, word_of(17'h6, 5'b11111, 5'd0, 5'b11111));
        cyc(0, 0, 1, 0);
        chk("R5 jump wraps below 0", pc_out, 32'hFFFF_FFFF);
        cyc(0, 1, 0, 0);
        chk("R4 step wraps", pc_out, 32'd0);
        exp_pc = 0;
    endtask

    task automatic t_same_cycle();
        logic [31:0] o;
        cyc(1, 0, 0, word_of(17'h7, 5'd0, 5'd0, 5'd3));
        o = ofs_of(dst_sel, srcb_sel);
        cyc(1, 0, 1, word_of(17'h8, 5'b10101, 5'd2, 5'd9));
        exp_pc = exp_pc + o;
        chk("R9 old offset", pc_out, exp_pc);
        chk("R9 new word", 32'(opcode), 32'h8);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_fields();
        t_ir_hold();
        t_step_hold();
        t_jump_pos();
        t_jump_neg();
        t_both();
        t_same_cycle();
        t_wrap();
        t_reset();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        #800000;
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule